// File: doc/BRIEF.md
# Indexed and Auto-Increment Memory Access Decoder

This block takes one 32-bit instruction from a custom-opcode group of scaled-index and auto-increment memory operations. It turns that instruction into a single memory request. The request gives the access address, the access size, whether a load is unsigned, and whether the operation is a load or a store. For the auto-increment forms the block also gives a base-register update. The result is either the new base value or nothing. When an encoding is invalid in the current configuration, the block raises an illegal flag instead of a request.

The decoder sits beside the register read stage of a pipeline. The two source register values arrive with the instruction. A mode input chooses 64-bit or 32-bit arithmetic, and an enable input switches the whole group on or off. The decode and address arithmetic are combinational. Parameter `OUT_REG` adds one register stage on the outputs, so results appear one clock after `in_valid`. With `OUT_REG=0` the results appear in the same cycle.

Top module: `idxmem_agu`

## Requirements
- R1: Only words with bits[6:0]=0001011 and bits[14:12] equal to 100 (load) or 101 (store) belong to the group. Any other word, or a cycle without `in_valid`, raises neither `out_valid` nor `illegal`.
- R2: For an accepted word, `is_load` is 1 for funct3=100. `size` equals bits[30:29], where 0 is byte, 1 is halfword, 2 is word and 3 is doubleword. `is_unsigned` equals bit31.
- R3: When bit27=0 and bit28=0, the address is rs1 + (rs2 << bits[26:25]), using all of rs2.
- R4: When bit27=0 and bit28=1, the address is rs1 + (zero-extended rs2[31:0] << bits[26:25]).
- R5: When bit27=1, the increment is the sign-extended 5-bit field bits[24:20] shifted left by bits[26:25]. When bit28=0 (pre-increment), the address is rs1 plus the increment.
- R6: When bit27=1 and bit28=1 (post-increment), the address is rs1 unmodified.
- R7: `wb_en` is 1 and `wb_val` is rs1 plus the increment for every accepted increment form, load or store. For the register-indexed forms, `wb_en` is 0.
- R8: An increment-form load whose bits[19:15] equal bits[11:7] is illegal. An increment-form store with equal fields is legal.
- R9: These encodings are illegal: a doubleword access in 32-bit mode, an unsigned word load in 32-bit mode, any unsigned doubleword load, and any store with bit31 set.
- R10: When `ext_en` is 0, every word of the group raises `illegal` and never `out_valid`.
- R11: When `mode64` is 0, all address and update arithmetic is done modulo 2^32 on rs1[31:0] and rs2[31:0], and output bits above bit 31 are zero. When `mode64` is 1, arithmetic is modulo 2^XLEN.
- R12: `out_valid` and `illegal` are never 1 together. With `OUT_REG=1` the results of an input cycle appear after the next rising clock edge. All outputs are 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and operands are present |
| instr | input | 32 | Instruction word |
| rs1_val | input | XLEN | Base register value |
| rs2_val | input | XLEN | Index register value |
| mode64 | input | 1 | 1: 64-bit arithmetic, 0: 32-bit arithmetic |
| ext_en | input | 1 | Enables the instruction group |
| out_valid | output | 1 | A legal request is presented |
| is_load | output | 1 | Request is a load |
| size | output | 2 | Access size, log2 of bytes |
| is_unsigned | output | 1 | Load result is zero-extended |
| addr | output | XLEN | Access address |
| wb_en | output | 1 | Base register update is required |
| wb_val | output | XLEN | New base register value |
| illegal | output | 1 | Group encoding that is not allowed |

## Verification
In the increment forms, the access address and the base update are produced in the same cycle from one shared sum. In the pre-increment form both outputs carry that sum. In the post-increment form they differ. The bench applies increment loads and stores with negative immediates and every shift amount, and compares both outputs against a model written from the requirements. In the same cycle, a load whose base and destination fields are equal must change that pair into an illegal flag. The bench drives such loads, and also stores with the same field values, and judges them at the ports.

// File: rtl/idxmem_pkg.sv
package idxmem_pkg;

  localparam logic [6:0] OPC_GROUP = 7'b0001011;
  localparam logic [2:0] F3_LOAD   = 3'b100;
  localparam logic [2:0] F3_STORE  = 3'b101;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic      hit;
    logic      bad;
    logic      load;
    logic      uns;
    acc_size_e size;
    logic      incr;
    logic      alt;     // post-increment or zero-extended index
    logic [1:0] shamt;
    logic [4:0] imm5;
  } dec_t;

endpackage

// File: rtl/idxmem_decode.sv
module idxmem_decode
  import idxmem_pkg::*;
(
  input  logic        in_valid,
  input  logic [31:0] instr,
  input  logic        mode64,
  input  logic        ext_en,
  output dec_t        dec
);

  logic [6:0] opc;
  logic [2:0] f3;
  logic [4:0] base_f;
  logic [4:0] dst_f;
  logic       match;
  logic       is_ld;
  logic       uns;
  acc_size_e  sz;
  logic       incr;
  logic       rule_off;
  logic       rule_ustore;
  logic       rule_udbl;
  logic       rule_dbl32;
  logic       rule_uw32;
  logic       rule_overlap;
  logic       reject;

  always_comb begin
    opc    = instr[6:0];
    f3     = instr[14:12];
    base_f = instr[19:15];
    dst_f  = instr[11:7];
    is_ld  = (f3 == F3_LOAD);
    match  = in_valid && (opc == OPC_GROUP) && (is_ld || (f3 == F3_STORE));
    uns    = instr[31];
    sz     = acc_size_e'(instr[30:29]);
    incr   = instr[27];
  end

  always_comb begin
    rule_off     = !ext_en;
    rule_ustore  = !is_ld && uns;
    rule_udbl    = uns && (sz == SZ_DBL);
    rule_dbl32   = !mode64 && (sz == SZ_DBL);
    rule_uw32    = !mode64 && is_ld && uns && (sz == SZ_WORD);
    rule_overlap = incr && is_ld && (base_f == dst_f);
    reject       = rule_off | rule_ustore | rule_udbl | rule_dbl32 |
                   rule_uw32 | rule_overlap;
  end

  always_comb begin
    dec.hit   = match && !reject;
    dec.bad   = match && reject;
    dec.load  = is_ld;
    dec.uns   = uns;
    dec.size  = sz;
    dec.incr  = incr;
    dec.alt   = instr[28];
    dec.shamt = instr[26:25];
    dec.imm5  = instr[24:20];
  end

endmodule

// File: rtl/idxmem_addr.sv
module idxmem_addr
  import idxmem_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  dec_t            dec,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] rs2_val,
  input  logic            mode64,
  output logic [XLEN-1:0] addr,
  output logic [XLEN-1:0] upd
);

  localparam logic [XLEN-1:0] LO32 = XLEN'(64'hFFFF_FFFF);

  logic [XLEN-1:0] mask;
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] index;
  logic [XLEN-1:0] scaled;
  logic [XLEN-1:0] step;
  logic [XLEN-1:0] idx_sum;
  logic [XLEN-1:0] inc_sum;

  always_comb begin
    mask   = mode64 ? '1 : LO32;
    base   = rs1_val & mask;
    index  = dec.alt ? XLEN'(rs2_val[31:0]) : (rs2_val & mask);
    scaled = index << dec.shamt;
    step   = {{(XLEN-5){dec.imm5[4]}}, dec.imm5} << dec.shamt;
    idx_sum = (base + scaled) & mask;
    inc_sum = (base + step) & mask;
  end

  always_comb begin
    upd = inc_sum;
    if (dec.incr) addr = dec.alt ? base : inc_sum;
    else          addr = idx_sum;
  end

endmodule

// File: rtl/idxmem_outreg.sv
module idxmem_outreg #(
  parameter int XLEN    = 64,
  parameter bit OUT_REG = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_en,
  input  logic            v_d,
  input  logic            ld_d,
  input  logic [1:0]      sz_d,
  input  logic            un_d,
  input  logic [XLEN-1:0] ad_d,
  input  logic            we_d,
  input  logic [XLEN-1:0] wv_d,
  input  logic            il_d,
  output logic            v_q,
  output logic            ld_q,
  output logic [1:0]      sz_q,
  output logic            un_q,
  output logic [XLEN-1:0] ad_q,
  output logic            we_q,
  output logic [XLEN-1:0] wv_q,
  output logic            il_q
);

  if (OUT_REG) begin : g_reg
    logic            v_r, ld_r, un_r, we_r, il_r;
    logic [1:0]      sz_r;
    logic [XLEN-1:0] ad_r, wv_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_r  <= 1'b0;
        ld_r <= 1'b0;
        un_r <= 1'b0;
        we_r <= 1'b0;
        il_r <= 1'b0;
        sz_r <= '0;
      end else begin
        v_r  <= v_d;
        ld_r <= ld_d;
        un_r <= un_d;
        we_r <= we_d;
        il_r <= il_d;
        sz_r <= sz_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ad_r <= '0;
        wv_r <= '0;
      end else if (cap_en) begin
        ad_r <= ad_d;
        wv_r <= wv_d;
      end
    end

    always_comb begin
      v_q  = v_r;
      ld_q = ld_r;
      sz_q = sz_r;
      un_q = un_r;
      we_q = we_r;
      il_q = il_r;
      ad_q = v_r ? ad_r : '0;
      wv_q = we_r ? wv_r : '0;
    end
  end else begin : g_comb
    logic unused_clk;
    always_comb begin
      unused_clk = clk ^ rst_n ^ cap_en;
      v_q  = v_d;
      ld_q = ld_d;
      sz_q = sz_d;
      un_q = un_d;
      ad_q = ad_d;
      we_q = we_d;
      wv_q = wv_d;
      il_q = il_d;
    end
  end

endmodule

// File: rtl/idxmem_agu.sv
module idxmem_agu
  import idxmem_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter bit OUT_REG = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] rs2_val,
  input  logic            mode64,
  input  logic            ext_en,
  output logic            out_valid,
  output logic            is_load,
  output logic [1:0]      size,
  output logic            is_unsigned,
  output logic [XLEN-1:0] addr,
  output logic            wb_en,
  output logic [XLEN-1:0] wb_val,
  output logic            illegal
);

  dec_t            dec;
  logic [XLEN-1:0] raw_addr;
  logic [XLEN-1:0] raw_upd;

  logic            v_c, ld_c, un_c, we_c, il_c;
  logic [1:0]      sz_c;
  logic [XLEN-1:0] ad_c, wv_c;

  idxmem_decode u_dec (
    .in_valid (in_valid),
    .instr    (instr),
    .mode64   (mode64),
    .ext_en   (ext_en),
    .dec      (dec)
  );

  idxmem_addr #(.XLEN(XLEN)) u_addr (
    .dec     (dec),
    .rs1_val (rs1_val),
    .rs2_val (rs2_val),
    .mode64  (mode64),
    .addr    (raw_addr),
    .upd     (raw_upd)
  );

  always_comb begin
    v_c  = dec.hit;
    il_c = dec.bad;
    ld_c = dec.hit && dec.load;
    un_c = dec.hit && dec.uns;
    sz_c = dec.hit ? dec.size : 2'd0;
    we_c = dec.hit && dec.incr;
    ad_c = dec.hit ? raw_addr : '0;
    wv_c = we_c ? raw_upd : '0;
  end

  idxmem_outreg #(.XLEN(XLEN), .OUT_REG(OUT_REG)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (in_valid),
    .v_d    (v_c),
    .ld_d   (ld_c),
    .sz_d   (sz_c),
    .un_d   (un_c),
    .ad_d   (ad_c),
    .we_d   (we_c),
    .wv_d   (wv_c),
    .il_d   (il_c),
    .v_q    (out_valid),
    .ld_q   (is_load),
    .sz_q   (size),
    .un_q   (is_unsigned),
    .ad_q   (addr),
    .we_q   (wb_en),
    .wv_q   (wb_val),
    .il_q   (illegal)
  );

endmodule

// File: rtl/idxmem_agu_chk.sv
module idxmem_agu_chk #(
  parameter int XLEN    = 64,
  parameter bit OUT_REG = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [31:0]     instr,
  input logic            mode64,
  input logic            ext_en,
  input logic            out_valid,
  input logic            is_load,
  input logic            is_unsigned,
  input logic [XLEN-1:0] addr,
  input logic            wb_en,
  input logic [XLEN-1:0] wb_val,
  input logic            illegal
);

  logic grp_c, quiet_c, off_c, narrow_c, overlap_c;
  logic quiet_d, off_d, narrow_d, overlap_d;

  always_comb begin
    grp_c     = in_valid && (instr[6:0] == 7'b0001011) &&
                ((instr[14:12] == 3'b100) || (instr[14:12] == 3'b101));
    quiet_c   = !grp_c;
    off_c     = grp_c && !ext_en;
    narrow_c  = in_valid && !mode64;
    overlap_c = grp_c && (instr[14:12] == 3'b100) && instr[27] &&
                (instr[19:15] == instr[11:7]);
  end

  if (OUT_REG) begin : g_dly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        quiet_d   <= 1'b1;
        off_d     <= 1'b0;
        narrow_d  <= 1'b0;
        overlap_d <= 1'b0;
      end else begin
        quiet_d   <= quiet_c;
        off_d     <= off_c;
        narrow_d  <= narrow_c;
        overlap_d <= overlap_c;
      end
    end
  end else begin : g_nodly
    always_comb begin
      quiet_d   = quiet_c;
      off_d     = off_c;
      narrow_d  = narrow_c;
      overlap_d = overlap_c;
    end
  end

  a_r12_valid_xor_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && illegal));

  a_r1_foreign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_d |-> (!out_valid && !illegal));

  a_r10_disabled_flag: assert property (@(posedge clk) disable iff (!rst_n)
    off_d |-> (illegal && !out_valid));

  a_r8_overlap_load: assert property (@(posedge clk) disable iff (!rst_n)
    overlap_d |-> !out_valid);

  a_r7_wb_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> out_valid);

  a_r9_store_signed: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !is_load) |-> !is_unsigned);

  a_r11_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (narrow_d && out_valid) |-> ((addr >> 32) == '0 && (wb_val >> 32) == '0));

endmodule

bind idxmem_agu idxmem_agu_chk #(.XLEN(XLEN), .OUT_REG(OUT_REG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .instr       (instr),
  .mode64      (mode64),
  .ext_en      (ext_en),
  .out_valid   (out_valid),
  .is_load     (is_load),
  .is_unsigned (is_unsigned),
  .addr        (addr),
  .wb_en       (wb_en),
  .wb_val      (wb_val),
  .illegal     (illegal)
);

// File: tb/idxmem_agu_bench.sv
`timescale 1ns/1ps
module idxmem_agu_bench;

  typedef struct packed {
    logic        v;
    logic        ld;
    logic [1:0]  sz;
    logic        un;
    logic [63:0] ad;
    logic        we;
    logic [63:0] wv;
    logic        il;
  } res_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] instr;
  logic [63:0] rs1_val, rs2_val;
  logic        mode64, ext_en;
  logic        out_valid, is_load, is_unsigned, wb_en, illegal;
  logic [1:0]  size;
  logic [63:0] addr, wb_val;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  idxmem_agu #(.XLEN(64), .OUT_REG(1'b1)) u_idxmem_agu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .rs1_val(rs1_val), .rs2_val(rs2_val), .mode64(mode64), .ext_en(ext_en),
    .out_valid(out_valid), .is_load(is_load), .size(size),
    .is_unsigned(is_unsigned), .addr(addr), .wb_en(wb_en), .wb_val(wb_val),
    .illegal(illegal)
  );

  function automatic logic [31:0] enc(input logic [4:0] top, input logic [1:0] sh,
                                      input logic [4:0] mid, input logic [4:0] b,
                                      input logic [2:0] f3, input logic [4:0] d);
    return {top, sh, mid, b, f3, d, 7'b0001011};
  endfunction

  function automatic res_t model(input logic [31:0] w, input logic [63:0] a,
                                 input logic [63:0] b, input logic m64, input logic en);
    res_t r;
    logic ld, un, inc, alt, bad;
    logic [1:0] sz;
    logic [63:0] mask, base, idx, step, nb;
    r = '0;
    if (w[6:0] != 7'b0001011 || (w[14:12] != 3'b100 && w[14:12] != 3'b101)) return r;
    ld = (w[14:12] == 3'b100);
    un = w[31]; sz = w[30:29]; alt = w[28]; inc = w[27];
    bad = !en || (!ld && un) || (un && sz == 2'd3) || (!m64 && sz == 2'd3) ||
          (!m64 && ld && un && sz == 2'd2) || (inc && ld && w[19:15] == w[11:7]);
    if (bad) begin r.il = 1'b1; return r; end
    mask = m64 ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    base = a & mask;
    if (inc) begin
      step = {{59{w[24]}}, w[24:20]} << w[26:25];
      nb   = (base + step) & mask;
      r.ad = alt ? base : nb;
      r.we = 1'b1;
      r.wv = nb;
    end else begin
      idx  = alt ? {32'h0, b[31:0]} : (b & mask);
      r.ad = (base + (idx << w[26:25])) & mask;
    end
    r.v = 1'b1; r.ld = ld; r.sz = sz; r.un = un;
    return r;
  endfunction

  function automatic res_t observed();
    res_t r;
    r.v = out_valid; r.ld = is_load; r.sz = size; r.un = is_unsigned;
    r.ad = addr; r.we = wb_en; r.wv = wb_val; r.il = illegal;
    return r;
  endfunction

  task automatic check(input string tag, input res_t got, input res_t exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got v=%0b ld=%0b sz=%0d un=%0b ad=%h we=%0b wv=%h il=%0b exp v=%0b ld=%0b sz=%0d un=%0b ad=%h we=%0b wv=%h il=%0b",
               tag, got.v, got.ld, got.sz, got.un, got.ad, got.we, got.wv, got.il,
               exp.v, exp.ld, exp.sz, exp.un, exp.ad, exp.we, exp.wv, exp.il);
    end
    if (got.v && got.il) begin
      checks++; errors++;
      $display("FAIL R12 %s got valid=1 illegal=1 exp not both", tag);
    end
  endtask

  // Drive on the falling edge; registered result is read just after the next rising edge.
  task automatic drive(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b,
                       input logic m64, input logic en, output res_t got);
    @(negedge clk);
    in_valid = 1'b1; instr = w; rs1_val = a; rs2_val = b; mode64 = m64; ext_en = en;
    @(posedge clk); #1;
    got = observed();
  endtask

  task automatic apply(input string tag, input logic [31:0] w, input logic [63:0] a,
                       input logic [63:0] b, input logic m64, input logic en);
    res_t got;
    drive(w, a, b, m64, en, got);
    check(tag, got, model(w, a, b, m64, en));
  endtask

  task automatic apply_fixed(input string tag, input logic [31:0] w, input logic [63:0] a,
                             input logic [63:0] b, input logic m64, input res_t exp);
    res_t got;
    drive(w, a, b, m64, 1'b1, got);
    check(tag, got, exp);
  endtask

  function automatic res_t mk(input logic v, input logic ld, input logic [1:0] sz,
                              input logic un, input logic [63:0] ad, input logic we,
                              input logic [63:0] wv, input logic il);
    res_t r;
    r.v = v; r.ld = ld; r.sz = sz; r.un = un; r.ad = ad; r.we = we; r.wv = wv; r.il = il;
    return r;
  endfunction

  task automatic t_reset();
    checks++;
    if (out_valid !== 1'b0 || illegal !== 1'b0 || wb_en !== 1'b0 || addr !== 64'h0) begin
      errors++;
      $display("FAIL R12 reset got v=%0b il=%0b we=%0b ad=%h exp all zero",
               out_valid, illegal, wb_en, addr);
    end
  endtask

  task automatic t_foreign();
    apply("R1 other opcode", 32'h0062_8233, 64'h10, 64'h20, 1'b1, 1'b1);
    apply("R1 funct3 110", enc(5'b01100, 2'd0, 5'd2, 5'd3, 3'b110, 5'd4), 64'h10, 64'h20, 1'b1, 1'b1);
    apply_fixed("R1 idle cycle", 32'h0, 64'h0, 64'h0, 1'b1, '0);
  endtask

  task automatic t_indexed();
    apply_fixed("R3 full index shift2", enc(5'b01100, 2'd2, 5'd2, 5'd3, 3'b100, 5'd4),
                64'h100, 64'hF000_0000_0000_0010, 1'b1,
                mk(1, 1, 2'd3, 0, 64'hC000_0000_0000_0140, 0, 64'h0, 0));
    apply_fixed("R4 zext index shift2", enc(5'b01110, 2'd2, 5'd2, 5'd3, 3'b100, 5'd4),
                64'h100, 64'hF000_0000_0000_0010, 1'b1,
                mk(1, 1, 2'd3, 0, 64'h140, 0, 64'h0, 0));
    apply_fixed("R4 zext drops upper rs2", enc(5'b01010, 2'd0, 5'd2, 5'd3, 3'b101, 5'd4),
                64'h1000, 64'hFFFF_FFFF_8000_0000, 1'b1,
                mk(1, 0, 2'd2, 0, 64'h8000_1000, 0, 64'h0, 0));
  endtask

  task automatic t_increment();
    apply_fixed("R5 pre-inc imm -1 shift3", enc(5'b01101, 2'd3, 5'b11111, 5'd5, 3'b100, 5'd6),
                64'h1000, 64'h0, 1'b1, mk(1, 1, 2'd3, 0, 64'hFF8, 1, 64'hFF8, 0));
    apply_fixed("R6 post-inc imm -1 shift3", enc(5'b01111, 2'd3, 5'b11111, 5'd5, 3'b100, 5'd6),
                64'h1000, 64'h0, 1'b1, mk(1, 1, 2'd3, 0, 64'h1000, 1, 64'hFF8, 0));
    apply_fixed("R7 post-inc store wb", enc(5'b01011, 2'd1, 5'd4, 5'd5, 3'b101, 5'd6),
                64'h2000, 64'h0, 1'b1, mk(1, 0, 2'd2, 0, 64'h2000, 1, 64'h2008, 0));
    apply_fixed("R7 indexed store no wb", enc(5'b00000, 2'd0, 5'd1, 5'd5, 3'b101, 5'd6),
                64'h2000, 64'h3, 1'b1, mk(1, 0, 2'd0, 0, 64'h2003, 0, 64'h0, 0));
  endtask

  task automatic t_overlap();
    apply_fixed("R8 inc load rs1==rd", enc(5'b00011, 2'd0, 5'd1, 5'd9, 3'b100, 5'd9),
                64'h40, 64'h0, 1'b1, mk(0, 0, 2'd0, 0, 64'h0, 0, 64'h0, 1));
    apply_fixed("R8 inc store rs1==rd", enc(5'b00011, 2'd0, 5'd1, 5'd9, 3'b101, 5'd9),
                64'h40, 64'h0, 1'b1, mk(1, 0, 2'd0, 0, 64'h40, 1, 64'h41, 0));
    apply_fixed("R8 indexed load rs1==rd", enc(5'b00000, 2'd0, 5'd1, 5'd9, 3'b100, 5'd9),
                64'h40, 64'h2, 1'b1, mk(1, 1, 2'd0, 0, 64'h42, 0, 64'h0, 0));
  endtask

  task automatic t_modes();
    res_t ill;
    ill = mk(0, 0, 2'd0, 0, 64'h0, 0, 64'h0, 1);
    apply("R9 dword in 32-bit", enc(5'b01100, 2'd0, 5'd1, 5'd2, 3'b100, 5'd3), 64'h8, 64'h8, 1'b0, 1'b1);
    apply_fixed("R9 lwu 64-bit legal", enc(5'b11000, 2'd0, 5'd1, 5'd2, 3'b100, 5'd3),
                64'h8, 64'h8, 1'b1, mk(1, 1, 2'd2, 1, 64'h10, 0, 64'h0, 0));
    drive(enc(5'b11000, 2'd0, 5'd1, 5'd2, 3'b100, 5'd3), 64'h8, 64'h8, 1'b0, 1'b1, ill);
    check("R9 lwu 32-bit", ill, mk(0, 0, 2'd0, 0, 64'h0, 0, 64'h0, 1));
    apply("R9 unsigned store", enc(5'b10000, 2'd0, 5'd1, 5'd2, 3'b101, 5'd3), 64'h8, 64'h8, 1'b1, 1'b1);
    apply("R9 unsigned dword", enc(5'b11100, 2'd0, 5'd1, 5'd2, 3'b100, 5'd3), 64'h8, 64'h8, 1'b1, 1'b1);
    apply_fixed("R2 lhu 32-bit legal", enc(5'b10100, 2'd1, 5'd1, 5'd2, 3'b100, 5'd3),
                64'h8, 64'h8, 1'b0, mk(1, 1, 2'd1, 1, 64'h18, 0, 64'h0, 0));
  endtask

  task automatic t_disable();
    res_t got;
    drive(enc(5'b00000, 2'd0, 5'd1, 5'd2, 3'b100, 5'd3), 64'h8, 64'h8, 1'b1, 1'b0, got);
    check("R10 disabled byte load", got, mk(0, 0, 2'd0, 0, 64'h0, 0, 64'h0, 1));
    apply("R10 disabled inc store", enc(5'b01011, 2'd0, 5'd1, 5'd2, 3'b101, 5'd3), 64'h8, 64'h8, 1'b0, 1'b0);
  endtask

  task automatic t_wrap();
    apply_fixed("R11 32-bit index wrap", enc(5'b01000, 2'd1, 5'd1, 5'd2, 3'b100, 5'd3),
                64'hABCD_0123_FFFF_FFF0, 64'h5555_0000_0000_0010, 1'b0,
                mk(1, 1, 2'd2, 0, 64'h10, 0, 64'h0, 0));
    apply_fixed("R11 32-bit pre-dec wrap", enc(5'b01001, 2'd2, 5'b11110, 5'd2, 3'b101, 5'd3),
                64'hFFFF_FFFF_0000_0004, 64'h0, 1'b0,
                mk(1, 0, 2'd2, 0, 64'hFFFF_FFFC, 1, 64'hFFFF_FFFC, 0));
    apply_fixed("R11 64-bit carry kept", enc(5'b01000, 2'd0, 5'd1, 5'd2, 3'b100, 5'd3),
                64'h0000_0000_FFFF_FFFF, 64'h1, 1'b1,
                mk(1, 1, 2'd2, 0, 64'h1_0000_0000, 0, 64'h0, 0));
  endtask

  task automatic t_sweep();
    logic [63:0] aset [3];
    logic [63:0] bset [3];
    aset[0] = 64'h0000_0000_0000_1000; bset[0] = 64'h0000_0000_0000_0024;
    aset[1] = 64'h8765_4321_FFFF_FF00; bset[1] = 64'hFFFF_FFFF_FFFF_FFFE;
    aset[2] = 64'h7FFF_FFFF_FFFF_FFF8; bset[2] = 64'h1234_5678_9ABC_DEF0;
    for (int t = 0; t < 32; t++) begin
      for (int s = 0; s < 2; s++) begin
        for (int m = 0; m < 2; m++) begin
          for (int k = 0; k < 3; k++) begin
            apply("R2 sweep", enc(5'(t), 2'(t + k), 5'(5'd17 + 5'(t * 3 + k)), 5'd7,
                                  (s == 0) ? 3'b100 : 3'b101, 5'(k + 7)),
                  aset[k], bset[k], m[0], 1'b1);
          end
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got running exp finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; instr = '0; rs1_val = '0; rs2_val = '0;
    mode64 = 1'b1; ext_en = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_foreign();
    t_indexed();
    t_increment();
    t_overlap();
    t_modes();
    t_disable();
    t_wrap();
    t_sweep();
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;
    check("R12 drop after valid", observed(), '0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule